// File: doc/BRIEF.md
# Dual-Channel Audio Sample Conditioner

This block sits after the decimation filters of a two-channel audio front end. It takes two streams of 16-bit signed samples, each with its own valid strobe, and conditions each stream in three steps. A digital gain stage trims the level so the two channels can be matched. An optional first-order high-pass stage removes any DC component. A sample delay makes one channel lag the other by a programmed number of samples, which is used to steer a two-microphone beam.

Each channel runs on its own and can be switched off to save power. A switched-off channel ignores its input, freezes its internal state and raises no output strobe. The gain, the filter mode, the delay amount, the delay direction and the enables are static configuration inputs, driven from a register set outside the block. When the filter mode or the delay of a channel changes, that stage of the channel is cleared, so no stale history mixes with the new setting.

Top module: `dual_sample_conditioner`

## Requirements
- R1: The two channels are processed independently. Each has its own gain, filter mode and enable, and samples or settings on one channel never change the output of the other.
- R2: Gain is a 12-bit unsigned factor with 8 fractional bits (256 = unity). The gained sample is floor((x*gain + 128) / 256), saturated to the range -32768..32767.
- R3: The filter mode field fmodeN is encoded as 0 = bypass, 1 = 5 Hz (k = 10), 2 = 10 Hz (k = 9) and 3 = 20 Hz (k = 8). In modes 1 to 3 each sample gives y = sat(x - xp + yp - floor(yp / 2^k)), where x is the gained sample, xp and yp are the previous filter input and output, and sat limits to the 16-bit signed range. Then xp becomes x and yp becomes y.
- R4: In bypass mode (fmodeN = 0) the gained sample reaches the delay stage unchanged.
- R5: A change of a channel's filter mode sets that channel's xp and yp to zero.
- R6: dly_amt (0 to 31) sets the delay D. If dly_sel = 0, channel 1 is delayed and channel 0 gets no added delay. If dly_sel = 1, channel 0 is delayed. The delayed channel outputs the filter result of D samples earlier, or zero while fewer than D samples have entered since the last clear.
- R7: A change of a channel's effective delay (from dly_amt or dly_sel) clears that channel's delay history, so it outputs zeros again until it has refilled.
- R8: While enN = 0, channel N raises no out_validN and ignores its inputs. Its gain, filter and delay state are held, and processing resumes from that state when the channel is enabled again.
- R9: An accepted sample (in_validN = 1 with enN = 1) produces out_validN exactly 2 clock cycles later. out_dataN changes only together with out_validN.
- R10: During synchronous reset out_valid0/1 are 0 and out_data0/1 are 0, and all filter and delay state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en0 | input | 1 | Channel 0 enable |
| en1 | input | 1 | Channel 1 enable |
| gain0 | input | 12 | Channel 0 gain, unsigned 4.8 fixed point |
| gain1 | input | 12 | Channel 1 gain, unsigned 4.8 fixed point |
| fmode0 | input | 2 | Channel 0 DC filter mode |
| fmode1 | input | 2 | Channel 1 DC filter mode |
| dly_amt | input | 5 | Inter-channel delay in samples |
| dly_sel | input | 1 | Delay direction: 0 delays channel 1, 1 delays channel 0 |
| in_valid0 | input | 1 | Channel 0 sample strobe |
| in_data0 | input | 16 | Channel 0 signed sample |
| in_valid1 | input | 1 | Channel 1 sample strobe |
| in_data1 | input | 16 | Channel 1 signed sample |
| out_valid0 | output | 1 | Channel 0 result strobe |
| out_data0 | output | 16 | Channel 0 conditioned sample |
| out_valid1 | output | 1 | Channel 1 result strobe |
| out_data1 | output | 16 | Channel 1 conditioned sample |

## Verification
The pipeline checks assume that the configuration and the enables stay still while a sample is inside the two-stage pipeline. A setting that changes in mid-flight would clear a stage at the same edge it advances, and the result would then depend on that overlap. The stimulus therefore drops both strobes and waits several idle cycles before it changes any gain, mode, delay, direction or enable, and it resumes streaming only after further idle cycles. Within a stream, the sample strobes of the two channels are independent and irregular, and the data ranges from full-scale extremes to a DC offset with small noise.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int GAIN_W    = 12;
    localparam int GAIN_FRAC = 8;
    localparam int DELAY_MAX = 31;
    localparam int DELAY_W   = $clog2(DELAY_MAX + 1);
    localparam int NUM_CH    = 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        DC_OFF  = 2'd0,
        DC_5HZ  = 2'd1,
        DC_10HZ = 2'd2,
        DC_20HZ = 2'd3
    } dc_mode_e;

    typedef struct packed {
        logic [GAIN_W-1:0]  gain;
        dc_mode_e           mode;
        logic [DELAY_W-1:0] delay;
    } chan_cfg_t;

    // Clamp a wide signed value into the sample range.
    function automatic sample_t sat_sample(input logic signed [31:0] v);
        logic signed [31:0] hi;
        logic signed [31:0] lo;
        hi = (32'sd1 <<< (SAMPLE_W - 1)) - 32'sd1;
        lo = -hi - 32'sd1;
        if (v > hi)      return hi[SAMPLE_W-1:0];
        else if (v < lo) return lo[SAMPLE_W-1:0];
        else             return v[SAMPLE_W-1:0];
    endfunction

    // Feedback shift per mode; each step doubles the cutoff.
    function automatic int dc_shift(input dc_mode_e m);
        case (m)
            DC_5HZ:  return 10;
            DC_10HZ: return 9;
            DC_20HZ: return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sc_gain_stage.sv
module sc_gain_stage
    import sc_pkg::*;
#(
    parameter int GW = GAIN_W,
    parameter int GF = GAIN_FRAC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          in_valid,
    input  sample_t       in_data,
    input  logic [GW-1:0] gain,
    output logic          v1,
    output sample_t       g1
);

    localparam logic signed [31:0] HALF = 32'sd1 <<< (GF - 1);

    logic signed [31:0] xs, gs, prod, scaled;

    always_comb begin
        xs     = 32'(in_data);
        gs     = $signed(32'(gain));
        prod   = xs * gs;
        scaled = (prod + HALF) >>> GF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            g1 <= '0;
        end else begin
            v1 <= in_valid & en;
            if (in_valid & en) g1 <= sat_sample(scaled);
        end
    end

    // R9
    lat_in_chk: assert property (@(posedge clk) disable iff (rst)
        v1 |-> $past(in_valid && en));

endmodule

// File: rtl/sc_dc_filter.sv
module sc_dc_filter
    import sc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     adv,
    input  dc_mode_e mode,
    input  sample_t  x,
    output sample_t  y
);

    sample_t            xp, yp;
    logic signed [31:0] ypw, acc;

    always_comb begin
        ypw = 32'(yp);
        acc = 32'(x) - 32'(xp) + ypw - (ypw >>> dc_shift(mode));
        y   = (mode == DC_OFF) ? x : sat_sample(acc);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            xp <= '0;
            yp <= '0;
        end else if (adv) begin
            xp <= x;
            yp <= y;
        end
    end

    // R5
    flt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (y == x));

endmodule

// File: rtl/sc_delay_line.sv
module sc_delay_line
    import sc_pkg::*;
#(
    parameter int DMAX = DELAY_MAX
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       adv,
    input  logic [$clog2(DMAX+1)-1:0]  depth,
    input  sample_t                    din,
    output sample_t                    dout
);

    localparam int DW    = $clog2(DMAX + 1);
    localparam int SLOTS = DMAX + 1;
    localparam int PW    = $clog2(SLOTS);

    sample_t         mem [SLOTS];
    logic [PW-1:0]   wptr, rptr;
    logic [DW-1:0]   fill;

    always_comb begin
        int ri;
        ri = int'(wptr) - int'(depth);
        if (ri < 0) ri = ri + SLOTS;
        rptr = PW'(ri);
        if (depth == '0)       dout = din;
        else if (fill >= depth) dout = mem[rptr];
        else                   dout = '0;
    end

    always_ff @(posedge clk) begin
        if (adv) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            fill <= '0;
        end else if (adv) begin
            wptr <= (wptr == PW'(SLOTS - 1)) ? '0 : wptr + 1'b1;
            if (fill != DW'(DMAX)) fill <= fill + 1'b1;
        end
    end

    // R7
    dly_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (depth == '0 || dout == '0));

endmodule

// File: rtl/sc_channel.sv
module sc_channel
    import sc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      in_valid,
    input  sample_t   in_data,
    input  chan_cfg_t cfg,
    output logic      out_valid,
    output sample_t   out_data
);

    logic               v1, adv, clr_f, clr_d;
    sample_t            g1, fy, dy;
    dc_mode_e           mode_q;
    logic [DELAY_W-1:0] delay_q;

    assign adv   = v1 & en;
    assign clr_f = (cfg.mode  != mode_q);
    assign clr_d = (cfg.delay != delay_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= DC_OFF;
            delay_q <= '0;
        end else begin
            mode_q  <= cfg.mode;
            delay_q <= cfg.delay;
        end
    end

    sc_gain_stage u_gain (
        .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
        .in_data(in_data), .gain(cfg.gain), .v1(v1), .g1(g1)
    );

    sc_dc_filter u_flt (
        .clk(clk), .rst(rst), .clr(clr_f), .adv(adv),
        .mode(cfg.mode), .x(g1), .y(fy)
    );

    sc_delay_line #(.DMAX(DELAY_MAX)) u_dly (
        .clk(clk), .rst(rst), .clr(clr_d), .adv(adv),
        .depth(cfg.delay), .din(fy), .dout(dy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= adv;
            if (adv) out_data <= dy;
        end
    end

    // R9
    lat_out_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(v1));

endmodule

// File: rtl/dual_sample_conditioner.sv
module dual_sample_conditioner
    import sc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en0,
    input  logic                en1,
    input  logic [GAIN_W-1:0]   gain0,
    input  logic [GAIN_W-1:0]   gain1,
    input  logic [1:0]          fmode0,
    input  logic [1:0]          fmode1,
    input  logic [DELAY_W-1:0]  dly_amt,
    input  logic                dly_sel,
    input  logic                in_valid0,
    input  logic [SAMPLE_W-1:0] in_data0,
    input  logic                in_valid1,
    input  logic [SAMPLE_W-1:0] in_data1,
    output logic                out_valid0,
    output logic [SAMPLE_W-1:0] out_data0,
    output logic                out_valid1,
    output logic [SAMPLE_W-1:0] out_data1
);

    logic [NUM_CH-1:0] en_v, iv_v, ov_v;
    sample_t           id_a [NUM_CH];
    sample_t           od_a [NUM_CH];
    chan_cfg_t         cfg_a [NUM_CH];

    assign en_v    = {en1, en0};
    assign iv_v    = {in_valid1, in_valid0};
    assign id_a[0] = in_data0;
    assign id_a[1] = in_data1;

    always_comb begin
        cfg_a[0].gain  = gain0;
        cfg_a[0].mode  = dc_mode_e'(fmode0);
        cfg_a[0].delay = dly_sel ? dly_amt : '0;
        cfg_a[1].gain  = gain1;
        cfg_a[1].mode  = dc_mode_e'(fmode1);
        cfg_a[1].delay = dly_sel ? '0 : dly_amt;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sc_channel u_ch (
            .clk(clk), .rst(rst), .en(en_v[c]), .in_valid(iv_v[c]),
            .in_data(id_a[c]), .cfg(cfg_a[c]),
            .out_valid(ov_v[c]), .out_data(od_a[c])
        );
    end

    assign out_valid0 = ov_v[0];
    assign out_valid1 = ov_v[1];
    assign out_data0  = od_a[0];
    assign out_data1  = od_a[1];

    // R8
    ch_off0_chk: assert property (@(posedge clk) disable iff (rst)
        !en0 |=> !out_valid0);

    // R8
    ch_off1_chk: assert property (@(posedge clk) disable iff (rst)
        !en1 |=> !out_valid1);

endmodule

// File: tb/dual_sample_conditioner_test.sv
module dual_sample_conditioner_test;

    localparam int HALF_PS = 2500;  // 1 ps time unit: 200 MHz clock

    logic        clk = 1'b0;
    logic        rst;
    logic        en0, en1, dly_sel, in_valid0, in_valid1;
    logic [11:0] gain0, gain1;
    logic [1:0]  fmode0, fmode1;
    logic [4:0]  dly_amt;
    logic [15:0] in_data0, in_data1;
    logic        out_valid0, out_valid1;
    logic [15:0] out_data0, out_data1;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    string req    = "R10";

    always #(HALF_PS) clk = ~clk;

    dual_sample_conditioner uut (
        .clk(clk), .rst(rst), .en0(en0), .en1(en1),
        .gain0(gain0), .gain1(gain1), .fmode0(fmode0), .fmode1(fmode1),
        .dly_amt(dly_amt), .dly_sel(dly_sel),
        .in_valid0(in_valid0), .in_data0(in_data0),
        .in_valid1(in_valid1), .in_data1(in_data1),
        .out_valid0(out_valid0), .out_data0(out_data0),
        .out_valid1(out_valid1), .out_data1(out_data1)
    );

    // ---------------- behavioural reference ----------------
    int xp [2];
    int yp [2];
    int mq [2];
    int dq [2];
    int q0 [$];
    int q1 [$];
    bit ea_v [2];
    bit eb_v [2];
    int ea_d [2];
    int eb_d [2];

    function int sat(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function int model_step(int ch, int x, int g, int m);
        int p, xg, y, k, d, r;
        p  = x * g;
        xg = sat((p + 128) >>> 8);
        if (m == 0) y = xg;
        else begin
            k = (m == 1) ? 10 : (m == 2) ? 9 : 8;
            y = sat(xg - xp[ch] + yp[ch] - (yp[ch] >>> k));
        end
        xp[ch] = xg;
        yp[ch] = y;
        d = dq[ch];
        r = 0;
        if (ch == 0) begin
            q0.push_front(y);
            if (q0.size() > 40) void'(q0.pop_back());
            if (q0.size() > d) r = q0[d];
        end else begin
            q1.push_front(y);
            if (q1.size() > 40) void'(q1.pop_back());
            if (q1.size() > d) r = q1[d];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < 2; ch++) begin
                xp[ch] = 0; yp[ch] = 0; mq[ch] = 0; dq[ch] = 0;
                ea_v[ch] = 0; eb_v[ch] = 0; ea_d[ch] = 0; eb_d[ch] = 0;
            end
            q0.delete();
            q1.delete();
        end else begin
            for (int ch = 0; ch < 2; ch++) begin
                int g, m, d, x;
                bit en, iv;
                g  = (ch == 0) ? int'(gain0) : int'(gain1);
                m  = (ch == 0) ? int'(fmode0) : int'(fmode1);
                d  = (ch == 0) ? (dly_sel ? int'(dly_amt) : 0)
                               : (dly_sel ? 0 : int'(dly_amt));
                en = (ch == 0) ? en0 : en1;
                iv = (ch == 0) ? in_valid0 : in_valid1;
                x  = (ch == 0) ? int'($signed(in_data0)) : int'($signed(in_data1));
                eb_v[ch] = ea_v[ch];
                eb_d[ch] = ea_d[ch];
                if (m != mq[ch]) begin xp[ch] = 0; yp[ch] = 0; mq[ch] = m; end
                if (d != dq[ch]) begin
                    if (ch == 0) q0.delete(); else q1.delete();
                    dq[ch] = d;
                end
                ea_v[ch] = iv && en;
                if (ea_v[ch]) ea_d[ch] = model_step(ch, x, g, m);
            end
        end
    end

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        if (!rst) begin
            for (int ch = 0; ch < 2; ch++) begin
                bit ov;
                int od;
                ov = (ch == 0) ? out_valid0 : out_valid1;
                od = (ch == 0) ? int'($signed(out_data0)) : int'($signed(out_data1));
                checks++;
                if (ov !== eb_v[ch] || (eb_v[ch] && od != eb_d[ch])) begin
                    fails++;
                    $display("FAIL %s ch%0d cycle %0d: valid=%0b data=%0d expected valid=%0b data=%0d",
                             req, ch, cyc, ov, od, eb_v[ch], eb_d[ch]);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired: cycle=%0d expected end before 100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function logic [15:0] gen(int kind);
        case (kind)
            0:       return 16'($urandom);
            1:       return 16'(9000 + int'($urandom % 64) - 32);
            2:       return ($urandom % 2 == 0) ? 16'h7FFF : 16'h8000;
            default: return 16'(int'($urandom % 2001) - 1000);
        endcase
    endfunction

    task automatic settle();
        @(negedge clk);
        in_valid0 = 1'b0;
        in_valid1 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic stream(int n, int p0, int p1, int k0, int k1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid0 = int'($urandom % 100) < p0;
            in_valid1 = int'($urandom % 100) < p1;
            in_data0  = gen(k0);
            in_data1  = gen(k1);
        end
        settle();
    endtask

    task automatic reset_check(string tag, logic v, logic [15:0] d);
        checks++;
        if (v !== 1'b0 || d !== 16'h0) begin
            fails++;
            $display("FAIL %s reset: valid=%0b data=%0h expected valid=0 data=0", tag, v, d);
        end
    endtask

    initial begin
        rst = 1'b1;
        en0 = 1'b1; en1 = 1'b1;
        gain0 = 12'd256; gain1 = 12'd256;
        fmode0 = 2'd0; fmode1 = 2'd0;
        dly_amt = 5'd0; dly_sel = 1'b0;
        in_valid0 = 1'b0; in_valid1 = 1'b0;
        in_data0 = '0; in_data1 = '0;
        repeat (4) @(negedge clk);
        reset_check("R10", out_valid0, out_data0);
        reset_check("R10", out_valid1, out_data1);
        rst = 1'b0;
        settle();

        req = "R4 R9 unity bypass";
        stream(120, 70, 40, 0, 2);

        req = "R2 fractional gains";
        gain0 = 12'h180; gain1 = 12'h0C0;
        settle();
        stream(120, 60, 80, 0, 3);

        req = "R2 saturation and rounding";
        gain0 = 12'hFFF; gain1 = 12'h001;
        settle();
        stream(120, 90, 90, 2, 0);

        req = "R3 R1 dc filter modes";
        gain0 = 12'd256; gain1 = 12'd300;
        fmode0 = 2'd3; fmode1 = 2'd1;
        settle();
        stream(300, 80, 65, 1, 1);

        req = "R5 mode change clears";
        fmode0 = 2'd2; fmode1 = 2'd3;
        settle();
        stream(150, 75, 75, 1, 3);

        req = "R6 channel 1 lags";
        fmode0 = 2'd0; fmode1 = 2'd0;
        dly_amt = 5'd5; dly_sel = 1'b0;
        settle();
        stream(150, 70, 70, 0, 0);

        req = "R6 channel 0 lags by maximum";
        dly_amt = 5'd31; dly_sel = 1'b1;
        settle();
        stream(200, 85, 50, 3, 0);

        req = "R7 delay change clears";
        dly_amt = 5'd3;
        settle();
        stream(60, 60, 60, 0, 3);
        dly_sel = 1'b0;
        settle();
        stream(60, 60, 60, 3, 0);

        req = "R8 channel 1 disabled";
        fmode1 = 2'd2; dly_amt = 5'd4;
        settle();
        stream(40, 70, 70, 1, 1);
        en1 = 1'b0;
        settle();
        stream(80, 70, 90, 0, 0);
        en1 = 1'b1;
        settle();
        stream(60, 70, 70, 1, 1);

        req = "R8 channel 0 disabled";
        fmode0 = 2'd1;
        settle();
        stream(40, 70, 70, 1, 1);
        en0 = 1'b0;
        settle();
        stream(80, 90, 50, 2, 3);
        en0 = 1'b1;
        settle();
        stream(80, 70, 70, 1, 1);

        req = "R1 R9 back-to-back both channels";
        gain0 = 12'd200; gain1 = 12'd512;
        settle();
        stream(100, 100, 100, 0, 3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule